// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block sits beside a small 8-bit microcontroller core. It decides which of five request lines the core services next: external 0, timer 0, external 1, timer 1 and serial. Software writes an enable register and a priority register. The enable register has one bit per source and a master bit. The priority register places each source at a high or low service level. Requests that pass the enables are split by level and arbitrated in a fixed order within each level. A request is only accepted at an instruction boundary.

The block remembers which service levels are active, so nesting is limited. A high-level request may preempt a low-level routine that is running. A low-level request waits until every routine at its own level or above has returned. When a request is accepted, the block issues a one-cycle request pulse with the source's fixed entry address. For the two timer sources it also pulses a clear strobe back to that timer's overflow flag. The return-from-interrupt strobe closes the innermost active level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The issued vector is 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x001B for timer 1 and 0x0023 for serial, that is 3 + 8 × source index with indices 0 to 4 in that order.
- R2: After synchronous reset both registers are zero and `irq_valid` is low. With no register write, no request is taken even when lines and the boundary strobe are high.
- R3: In the enable register, bit 7 is the master enable and bits 0 to 4 enable sources 0 to 4. A source can be taken only when its bit and bit 7 are both set. Bits 5 and 6 have no effect.
- R4: In the priority register, bits 0 to 4 set sources 0 to 4 to the high level. Any enabled high-level request beats every low-level one. Within a level, the lowest source index wins.
- R5: The serial request is the OR of `ser_rx_done` and `ser_tx_done`. Either one alone is enough to raise it.
- R6: A request is taken only in a cycle where `insn_done` is 1 and `reti` is 0. `irq_valid` is then high for exactly the next cycle, with `irq_vector` valid in that same cycle.
- R7: A taken request marks its level as in service. While the high level is in service, nothing is taken. While only the low level is in service, only high-level requests are taken.
- R8: A `reti` pulse ends the high level if it is in service, and otherwise ends the low level. When neither level is active, `reti` has no effect.
- R9: `tmr_flag_clr[0]` pulses together with `irq_valid` when timer 0 is vectored, and `tmr_flag_clr[1]` does the same for timer 1. Both stay low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 4 | Request lines: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1 |
| ser_rx_done | input | 1 | Serial receive-complete flag |
| ser_tx_done | input | 1 | Serial transmit-complete flag |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data |
| pri_wr | input | 1 | Write strobe for the priority register |
| pri_wdata | input | 8 | Priority register write data |
| insn_done | input | 1 | Instruction-boundary strobe from the core |
| reti | input | 1 | Return-from-interrupt strobe from the core |
| irq_valid | output | 1 | One-cycle pulse: interrupt taken |
| irq_vector | output | 16 | Entry address of the taken source |
| tmr_flag_clr | output | 2 | Overflow-flag clear pulse for timer 0 (bit 0) and timer 1 (bit 1) |

## Verification
Arbitration is swept over all 32 priority settings against all 31 non-empty request patterns, with every source enabled. This separates the level split from the fixed in-level order. A second sweep holds all five lines high and walks every per-source enable mask, with the master bit both on and off. It shows that gating happens before arbitration, so a masked higher source never hides a lower one. Directed sequences cover the nesting rules: high preempts low, high blocks high, low waits for low. They also cover the order in which returns close levels, a return and a boundary strobe arriving together, and each serial flag alone.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NUM_SRC = 5;
  localparam int IDX_W   = $clog2(NUM_SRC);

  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } svc_level_e;

  typedef logic [IDX_W-1:0] src_idx_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import prio_irq_pkg::*;
#(
  parameter int REG_W   = 8,
  parameter int GLB_BIT = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_wr,
  input  logic [REG_W-1:0]   en_wdata,
  input  logic               pri_wr,
  input  logic [REG_W-1:0]   pri_wdata,
  output logic [NUM_SRC-1:0] src_en,
  output logic               glb_en,
  output logic [NUM_SRC-1:0] src_pri
);
  // Only the bits that steer arbitration are stored; the rest are dropped.
  always_ff @(posedge clk) begin
    if (rst) begin
      src_en  <= '0;
      glb_en  <= 1'b0;
      src_pri <= '0;
    end else begin
      if (en_wr) begin
        src_en <= en_wdata[NUM_SRC-1:0];
        glb_en <= en_wdata[GLB_BIT];
      end
      if (pri_wr) begin
        src_pri <= pri_wdata[NUM_SRC-1:0];
      end
    end
  end

  assert_master_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !en_wr |=> $stable(glb_en) && $stable(src_en));
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick
  import prio_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] cand,
  output logic               hit,
  output src_idx_t           idx
);
  // Scan downwards so the lowest set index is the last one written.
  always_comb begin
    hit = |cand;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) idx = src_idx_t'(i);
    end
  end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
  import prio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       take,
  input  svc_level_e take_lvl,
  input  logic       ret,
  output logic       svc_hi,
  output logic       svc_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      svc_hi <= 1'b0;
      svc_lo <= 1'b0;
    end else if (ret) begin
      if (svc_hi) svc_hi <= 1'b0;
      else        svc_lo <= 1'b0;
    end else if (take) begin
      if (take_lvl == LVL_HI) svc_hi <= 1'b1;
      else                    svc_lo <= 1'b1;
    end
  end

  assert_low_waits_R7: assert property (@(posedge clk) disable iff (rst)
    take && (take_lvl == LVL_LO) |-> !svc_hi && !svc_lo);

  assert_high_blocks_high_R7: assert property (@(posedge clk) disable iff (rst)
    take && (take_lvl == LVL_HI) |-> !svc_hi);

  assert_return_inner_first_R8: assert property (@(posedge clk) disable iff (rst)
    ret && svc_hi |=> !svc_hi && (svc_lo == $past(svc_lo)));

  assert_take_not_on_return_R6: assert property (@(posedge clk) disable iff (rst)
    !(take && ret));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int GLB_BIT    = 7,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int TMR0_IDX   = 1,
  parameter int TMR1_IDX   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        req_in,
  input  logic              ser_rx_done,
  input  logic              ser_tx_done,
  input  logic              en_wr,
  input  logic [REG_W-1:0]  en_wdata,
  input  logic              pri_wr,
  input  logic [REG_W-1:0]  pri_wdata,
  input  logic              insn_done,
  input  logic              reti,
  output logic              irq_valid,
  output logic [ADDR_W-1:0] irq_vector,
  output logic [1:0]        tmr_flag_clr
);
  localparam int NUM_LVL  = 2;
  localparam int VEC_LAST = VEC_BASE + (NUM_SRC - 1) * VEC_STRIDE;

  logic [NUM_SRC-1:0] src_en, src_pri, req_all, req_eff;
  logic               glb_en;
  logic               svc_hi, svc_lo;
  logic [NUM_SRC-1:0] lvl_cand [NUM_LVL];
  logic               lvl_hit  [NUM_LVL];
  src_idx_t           lvl_idx  [NUM_LVL];
  logic               hi_ok, lo_ok, take;
  svc_level_e         take_lvl;
  src_idx_t           win_idx;

  irq_cfg_regs #(.REG_W(REG_W), .GLB_BIT(GLB_BIT)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .en_wr    (en_wr),
    .en_wdata (en_wdata),
    .pri_wr   (pri_wr),
    .pri_wdata(pri_wdata),
    .src_en   (src_en),
    .glb_en   (glb_en),
    .src_pri  (src_pri)
  );

  assign req_all = {ser_rx_done | ser_tx_done, req_in};
  assign req_eff = req_all & src_en & {NUM_SRC{glb_en}};
  assign lvl_cand[LVL_HI] = req_eff & src_pri;
  assign lvl_cand[LVL_LO] = req_eff & ~src_pri;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    irq_level_pick u_pick (
      .cand(lvl_cand[g]),
      .hit (lvl_hit[g]),
      .idx (lvl_idx[g])
    );
  end

  assign hi_ok    = lvl_hit[LVL_HI] && !svc_hi;
  assign lo_ok    = lvl_hit[LVL_LO] && !svc_hi && !svc_lo;
  assign take     = insn_done && !reti && (hi_ok || lo_ok);
  assign take_lvl = hi_ok ? LVL_HI : LVL_LO;
  assign win_idx  = hi_ok ? lvl_idx[LVL_HI] : lvl_idx[LVL_LO];

  irq_svc_track u_svc (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .take_lvl(take_lvl),
    .ret     (reti),
    .svc_hi  (svc_hi),
    .svc_lo  (svc_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid    <= 1'b0;
      irq_vector   <= '0;
      tmr_flag_clr <= '0;
    end else begin
      irq_valid       <= take;
      tmr_flag_clr[0] <= take && (win_idx == src_idx_t'(TMR0_IDX));
      tmr_flag_clr[1] <= take && (win_idx == src_idx_t'(TMR1_IDX));
      if (take) begin
        irq_vector <= ADDR_W'(VEC_BASE) + ADDR_W'(win_idx) * ADDR_W'(VEC_STRIDE);
      end
    end
  end

  assert_vec_grid_R1: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> ((irq_vector - ADDR_W'(VEC_BASE)) % ADDR_W'(VEC_STRIDE) == '0)
                  && (irq_vector <= ADDR_W'(VEC_LAST)));

  assert_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> $past(insn_done) && !$past(reti));

  assert_clr_with_vec_R9: assert property (@(posedge clk) disable iff (rst)
    (|tmr_flag_clr) |-> irq_valid && $onehot0(tmr_flag_clr));

  assert_serial_source_R5: assert property (@(posedge clk) disable iff (rst)
    irq_valid && (irq_vector == ADDR_W'(VEC_LAST)) |-> $past(ser_rx_done || ser_tx_done));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  req_in;
  logic        ser_rx_done, ser_tx_done;
  logic        en_wr, pri_wr;
  logic [7:0]  en_wdata, pri_wdata;
  logic        insn_done, reti;
  logic        irq_valid;
  logic [15:0] irq_vector;
  logic [1:0]  tmr_flag_clr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst(rst), .req_in(req_in),
    .ser_rx_done(ser_rx_done), .ser_tx_done(ser_tx_done),
    .en_wr(en_wr), .en_wdata(en_wdata), .pri_wr(pri_wr), .pri_wdata(pri_wdata),
    .insn_done(insn_done), .reti(reti),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .tmr_flag_clr(tmr_flag_clr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_pick(input logic [4:0] rq, input logic [7:0] en,
                                    input logic [7:0] pr);
    logic [4:0] eff = rq & en[4:0] & {5{en[7]}};
    logic [4:0] hi  = eff & pr[4:0];
    logic [4:0] use_set = (hi != 0) ? hi : eff;
    for (int i = 0; i < 5; i++) if (use_set[i]) return i;
    return -1;
  endfunction

  task automatic wr_en(input logic [7:0] v);
    @(negedge clk); en_wr = 1'b1; en_wdata = v;
    @(negedge clk); en_wr = 1'b0;
  endtask

  task automatic wr_pri(input logic [7:0] v);
    @(negedge clk); pri_wr = 1'b1; pri_wdata = v;
    @(negedge clk); pri_wr = 1'b0;
  endtask

  task automatic set_req(input logic [4:0] v, input bit via_tx);
    req_in      = v[3:0];
    ser_rx_done = v[4] && !via_tx;
    ser_tx_done = v[4] && via_tx;
  endtask

  task automatic ret_pulse();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  // Boundary strobe for one cycle, then compare the registered outputs.
  task automatic take_chk(input int exp, input string tag);
    logic [1:0] exp_clr;
    @(negedge clk); insn_done = 1'b1;
    @(negedge clk); insn_done = 1'b0;
    if (exp < 0) begin
      chk(irq_valid == 1'b0, tag, irq_valid, 0);
    end else begin
      exp_clr = {exp == 3, exp == 1};
      chk(irq_valid == 1'b1, tag, irq_valid, 1);
      chk(irq_vector == 16'(3 + 8 * exp), tag, irq_vector, 3 + 8 * exp);
      chk(tmr_flag_clr == exp_clr, {tag, " R9"}, tmr_flag_clr, exp_clr);
    end
    @(negedge clk);
    chk(irq_valid == 1'b0 && tmr_flag_clr == 2'b00, {tag, " R6 pulse"}, irq_valid, 0);
  endtask

  initial begin
    rst = 1'b1; req_in = 4'hF; ser_rx_done = 1'b1; ser_tx_done = 1'b0;
    en_wr = 1'b0; pri_wr = 1'b0; en_wdata = '0; pri_wdata = '0;
    insn_done = 1'b1; reti = 1'b0;
    repeat (3) @(negedge clk);
    chk(irq_valid == 1'b0 && tmr_flag_clr == 2'b00, "R2 reset outputs", irq_valid, 0);
    rst = 1'b0; insn_done = 1'b0;
    take_chk(-1, "R2 no take after reset");

    // R4 sweep: every priority word against every non-empty request pattern.
    wr_en(8'h9F);
    for (int p = 0; p < 32; p++) begin
      wr_pri(8'(p));
      for (int r = 1; r < 32; r++) begin
        set_req(5'(r), r[0]);
        take_chk(model_pick(5'(r), 8'h9F, 8'(p)), "R4/R1 sweep");
        set_req(5'h00, 1'b0);
        ret_pulse();
      end
    end

    // R3 sweep: all lines high, each source mask with master off and on.
    wr_pri(8'h00);
    set_req(5'h1F, 1'b0);
    for (int g = 0; g < 2; g++) begin
      for (int m = 0; m < 32; m++) begin
        wr_en({1'(g), 2'b11, 5'(m)});
        take_chk(model_pick(5'h1F, {1'(g), 2'b00, 5'(m)}, 8'h00), "R3 mask");
        ret_pulse();
      end
    end

    // R5: each serial flag alone raises the serial request.
    wr_en(8'h90);
    set_req(5'h00, 1'b0); ser_rx_done = 1'b1;
    take_chk(4, "R5 rx only"); ser_rx_done = 1'b0; ret_pulse();
    ser_tx_done = 1'b1;
    take_chk(4, "R5 tx only"); ser_tx_done = 1'b0; ret_pulse();
    take_chk(-1, "R5 neither");

    // R6: return strobe in the same cycle as the boundary blocks the take.
    wr_en(8'h9F);
    set_req(5'h01, 1'b0);
    @(negedge clk); insn_done = 1'b1; reti = 1'b1;
    @(negedge clk); insn_done = 1'b0; reti = 1'b0;
    chk(irq_valid == 1'b0, "R6 no take with reti", irq_valid, 0);
    take_chk(0, "R6 later boundary");
    set_req(5'h00, 1'b0); ret_pulse();

    // R7/R8 nesting: external 1 at high level.
    wr_pri(8'h04);
    set_req(5'h01, 1'b0);
    take_chk(0, "R7 low taken");
    set_req(5'h02, 1'b0);
    take_chk(-1, "R7 low waits for low");
    set_req(5'h06, 1'b0);
    take_chk(2, "R7 high preempts low");
    set_req(5'h02, 1'b0);
    take_chk(-1, "R7 high blocks low");
    ret_pulse();
    take_chk(-1, "R8 low still in service");
    ret_pulse();
    take_chk(1, "R8 low closed, timer 0 taken");
    set_req(5'h00, 1'b0); ret_pulse();

    // R7: high blocks another high; R8 return order.
    wr_pri(8'h0C);
    set_req(5'h04, 1'b0);
    take_chk(2, "R7 high taken");
    set_req(5'h08, 1'b0);
    take_chk(-1, "R7 high blocks high");
    ret_pulse();
    take_chk(3, "R8 timer 1 after return");
    set_req(5'h00, 1'b0); ret_pulse();
    ret_pulse();
    set_req(5'h01, 1'b0);
    take_chk(0, "R8 spare return ignored");
    set_req(5'h00, 1'b0); ret_pulse();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R6 actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule